// File: doc/BRIEF.md
# Dual-Ring Receive Buffer Pointer Manager

This block keeps the hardware-side pointers of a receive DMA engine that draws empty buffers from two free-buffer rings and reports every stored frame through a packet-status ring. One free ring holds small buffers and the other holds large ones. Software returns buffers by moving each ring's "full" position forward. The block consumes one descriptor per accepted frame, from the ring whose buffer size fits the frame. It then writes a status entry that names the ring and the slot used, and advances a status writeback position that software compares with its own consumed position.

Every position is an index plus a separate wrap bit. Ring sizes are programmed as the entry count minus one, and a low-water flag per free ring warns when few descriptors remain. A control register enables the rings, selects their buffer sizes and halts the engine. A halted engine takes no frames. Frame reception and the memory master sit outside the block: a frame shows up as a one-cycle valid with its length, and a status entry shows up as a one-cycle output pulse.

Top module: `rxring_ptr_mgr`

## Requirements
- R1: After reset the engine is halted, `wb_pos` is 0, `st_empty` is 1, `drop_cnt` is 0, `st_valid` and `drop_pulse` are 0, and both low-water flags are 0.
- R2: A write to select 0 loads the control register. Bit 0 requests a halt, and `halted` follows that bit one cycle after the write. Bit 13 enables the large ring and bits 12:11 hold its size code. Bit 10 enables the small ring and bits 9:8 hold its size code. Writing 0x2001 halts the engine with the large ring enabled at code 0.
- R3: While `halted` is 1, a frame produces no status entry and no drop, and `drop_cnt` does not change.
- R4: A frame goes to the small ring (ring 0) when that ring is enabled, its size code is nonzero and the length is at most 128 shifted left by the code (256, 512 or 1024). Any other frame goes to the large ring (ring 1), whose capacity is 2048 shifted left by its code. A frame that needs the large ring while that ring is disabled, or that is longer than its capacity, is dropped.
- R5: An accepted frame produces a one-cycle `st_valid` with `st_len` equal to the frame length, `st_ring` equal to the ring used, `st_bidx` equal to that ring's consumer index before the take, and `st_slot` equal to the status producer index before the write.
- R6: A free-ring position is a 10-bit index with its wrap bit at bit 10. A step past the programmed limit (count minus one) returns the index to 0 and toggles the wrap bit. With limit 1023 the carry out of the index toggles the wrap bit. The full position resets to 0x400, so every descriptor is available.
- R7: A free ring is empty when its consumer position equals its full position. A frame routed to an empty ring is dropped, `drop_pulse` is 1 for one cycle and `drop_cnt` rises by 1.
- R8: `wb_pos` holds the status producer position: a 12-bit index with its wrap bit at bit 12. It advances once per accepted frame and follows the same limit-and-wrap rule as the free rings.
- R9: `st_empty` is 1 when `wb_pos` equals the consumed position written at select 8. When the two indices are equal and the wrap bits differ, the status ring is full, and a frame is dropped and counted.
- R10: A free ring's low-water flag is 1 while its count of available descriptors is below its threshold. The thresholds are written at select 5 (small ring) and select 6 (large ring). The limits are written at selects 3 (small ring), 4 (large ring) and 7 (status ring). The full positions are written at selects 1 (small ring) and 2 (large ring).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 14 | Register write data |
| frm_valid | input | 1 | A frame is offered this cycle |
| frm_len | input | 16 | Length of the offered frame in bytes |
| st_valid | output | 1 | Status entry written (one cycle) |
| st_len | output | 16 | Status entry frame length |
| st_ring | output | 1 | Status entry ring, 0 small and 1 large |
| st_bidx | output | 10 | Status entry buffer index |
| st_slot | output | 12 | Status ring slot of the entry |
| wb_pos | output | 13 | Status writeback position, wrap at bit 12 |
| st_empty | output | 1 | Status ring holds no unconsumed entry |
| halted | output | 1 | Halt status |
| low_small | output | 1 | Small ring below its threshold |
| low_large | output | 1 | Large ring below its threshold |
| drop_pulse | output | 1 | A frame was dropped (one cycle) |
| drop_cnt | output | 16 | Count of dropped frames |

## Verification
A table of frame lengths below, at and just above the small-buffer size, plus one over the large capacity, shows whether the routing boundary and the oversize drop sit at the right byte. Running the small ring dry and then returning its buffers separates the "empty" comparison from the "available" one. More than a thousand large frames, each followed by a buffer return, take a 1024-entry ring through its index carry, so a wrap bit that fails to toggle shows up as a false drop. A burst of frames with nothing consumed fills the status ring and shows that the full case is told apart from the empty case. Halted frames and threshold steps of one descriptor cover the remaining controls.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FB_IW = 10;
  localparam int FB_PW = FB_IW + 1;
  localparam int ST_IW = 12;
  localparam int ST_PW = ST_IW + 1;
  localparam int LEN_W = 16;
  localparam int CNT_W = FB_IW + 1;
  localparam int WD_W  = 14;

  typedef enum logic [3:0] {
    SEL_CTRL    = 4'd0,
    SEL_SM_FULL = 4'd1,
    SEL_LG_FULL = 4'd2,
    SEL_SM_LIM  = 4'd3,
    SEL_LG_LIM  = 4'd4,
    SEL_SM_MIN  = 4'd5,
    SEL_LG_MIN  = 4'd6,
    SEL_ST_LIM  = 4'd7,
    SEL_ST_CONS = 4'd8
  } reg_sel_e;

  // Control bits 13..8: large enable, large code, small enable, small code.
  typedef struct packed {
    logic       lg_en;
    logic [1:0] lg_code;
    logic       sm_en;
    logic [1:0] sm_code;
  } ctrl_t;

  // Free-ring step. Truncation to FB_PW bits lets the index carry flip the wrap bit.
  function automatic logic [FB_PW-1:0] bump_fb(logic [FB_PW-1:0] pos, logic [FB_IW-1:0] lim);
    logic [FB_PW-1:0] v;
    v = pos + 1'b1;
    if (v[FB_IW-1:0] > lim) begin
      v[FB_IW-1:0] = '0;
      v[FB_IW]     = ~v[FB_IW];
    end
    return v;
  endfunction

  function automatic logic [ST_PW-1:0] bump_st(logic [ST_PW-1:0] pos, logic [ST_IW-1:0] lim);
    logic [ST_PW-1:0] v;
    v = pos + 1'b1;
    if (v[ST_IW-1:0] > lim) begin
      v[ST_IW-1:0] = '0;
      v[ST_IW]     = ~v[ST_IW];
    end
    return v;
  endfunction

  // Descriptors between the consumer and the software full position.
  function automatic logic [CNT_W-1:0] fb_count(logic [FB_PW-1:0] full, logic [FB_PW-1:0] cons,
                                                logic [FB_IW-1:0] lim);
    logic [CNT_W+1:0] t;
    if (full[FB_IW] != cons[FB_IW])
      t = {3'b0, lim} + 1 + {3'b0, full[FB_IW-1:0]} - {3'b0, cons[FB_IW-1:0]};
    else
      t = {3'b0, full[FB_IW-1:0]} - {3'b0, cons[FB_IW-1:0]};
    return t[CNT_W-1:0];
  endfunction

  function automatic logic [LEN_W:0] sm_bytes(logic [1:0] code);
    return (LEN_W+1)'(128) << code;
  endfunction

  function automatic logic [LEN_W:0] lg_bytes(logic [1:0] code);
    return (LEN_W+1)'(2048) << code;
  endfunction
endpackage

// File: rtl/rxr_free_ring.sv
module rxr_free_ring
  import rxr_pkg::*;
#(
  parameter int RST_LIM = 511
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_full,
  input  logic             wr_lim,
  input  logic             wr_min,
  input  logic [CNT_W-1:0] wdata,
  input  logic             take,
  output logic [FB_PW-1:0] cons_pos,
  output logic             avail,
  output logic             low
);
  logic [FB_PW-1:0] full_q, cons_q;
  logic [FB_IW-1:0] lim_q;
  logic [CNT_W-1:0] min_q;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= {1'b1, {FB_IW{1'b0}}};
      cons_q <= '0;
      lim_q  <= FB_IW'(RST_LIM);
      min_q  <= '0;
    end else begin
      if (wr_full) full_q <= wdata;
      if (wr_lim)  lim_q  <= wdata[FB_IW-1:0];
      if (wr_min)  min_q  <= wdata;
      if (take)    cons_q <= bump_fb(cons_q, lim_q);
    end
  end

  assign count    = fb_count(full_q, cons_q, lim_q);
  assign avail    = (cons_q != full_q);
  assign low      = (count < min_q);
  assign cons_pos = cons_q;
endmodule

// File: rtl/rxr_stat_ring.sv
module rxr_stat_ring
  import rxr_pkg::*;
#(
  parameter int RST_LIM = 1023
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lim,
  input  logic             wr_cons,
  input  logic [ST_PW-1:0] wdata,
  input  logic             push,
  output logic [ST_PW-1:0] prod_pos,
  output logic             empty,
  output logic             full
);
  logic [ST_PW-1:0] prod_q, cons_q;
  logic [ST_IW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      lim_q  <= ST_IW'(RST_LIM);
    end else begin
      if (wr_lim)  lim_q  <= wdata[ST_IW-1:0];
      if (wr_cons) cons_q <= wdata;
      if (push)    prod_q <= bump_st(prod_q, lim_q);
    end
  end

  assign empty    = (prod_q == cons_q);
  assign full     = (prod_q[ST_IW-1:0] == cons_q[ST_IW-1:0]) && (prod_q[ST_IW] != cons_q[ST_IW]);
  assign prod_pos = prod_q;
endmodule

// File: rtl/rxr_router.sv
module rxr_router
  import rxr_pkg::*;
(
  input  ctrl_t            ctrl,
  input  logic             halted,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             sm_avail,
  input  logic             lg_avail,
  input  logic             st_full,
  output logic             accept,
  output logic             drop,
  output logic             use_large
);
  logic fits_small, fits_large, ring_ok, go;

  always_comb begin
    fits_small = ctrl.sm_en && (ctrl.sm_code != 2'd0) &&
                 ({1'b0, frm_len} <= sm_bytes(ctrl.sm_code));
    fits_large = ctrl.lg_en && ({1'b0, frm_len} <= lg_bytes(ctrl.lg_code));
    use_large  = !fits_small;
    ring_ok    = use_large ? (fits_large && lg_avail) : sm_avail;
    go         = frm_valid && !halted;
    accept     = go && ring_ok && !st_full;
    drop       = go && !accept;
  end
endmodule

// File: rtl/rxring_ptr_mgr.sv
module rxring_ptr_mgr
  import rxr_pkg::*;
#(
  parameter int SM_RST_LIM = 511,
  parameter int LG_RST_LIM = 511,
  parameter int ST_RST_LIM = 1023
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_sel,
  input  logic [13:0] reg_wdata,
  input  logic        frm_valid,
  input  logic [15:0] frm_len,
  output logic        st_valid,
  output logic [15:0] st_len,
  output logic        st_ring,
  output logic [9:0]  st_bidx,
  output logic [11:0] st_slot,
  output logic [12:0] wb_pos,
  output logic        st_empty,
  output logic        halted,
  output logic        low_small,
  output logic        low_large,
  output logic        drop_pulse,
  output logic [15:0] drop_cnt
);
  localparam int NRING = 2;

  logic             halted_q;
  ctrl_t            ctrl_q;
  logic [NRING-1:0] ring_avail, ring_low, ring_take;
  logic [FB_PW-1:0] ring_cons [NRING];
  logic [ST_PW-1:0] st_prod;
  logic             st_full_w, acc_fire, drop_fire, use_large;
  logic [FB_PW-1:0] lg_cons_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b1;
      ctrl_q   <= '0;
    end else if (reg_wr && reg_sel == SEL_CTRL) begin
      halted_q <= reg_wdata[0];
      ctrl_q   <= reg_wdata[13:8];
    end
  end

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    localparam bit IS_LG = (g == 1);
    localparam reg_sel_e S_FULL = IS_LG ? SEL_LG_FULL : SEL_SM_FULL;
    localparam reg_sel_e S_LIM  = IS_LG ? SEL_LG_LIM  : SEL_SM_LIM;
    localparam reg_sel_e S_MIN  = IS_LG ? SEL_LG_MIN  : SEL_SM_MIN;
    assign ring_take[g] = acc_fire && (use_large == IS_LG);
    rxr_free_ring #(.RST_LIM(IS_LG ? LG_RST_LIM : SM_RST_LIM)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_full  (reg_wr && reg_sel == S_FULL),
      .wr_lim   (reg_wr && reg_sel == S_LIM),
      .wr_min   (reg_wr && reg_sel == S_MIN),
      .wdata    (reg_wdata[CNT_W-1:0]),
      .take     (ring_take[g]),
      .cons_pos (ring_cons[g]),
      .avail    (ring_avail[g]),
      .low      (ring_low[g])
    );
  end

  rxr_stat_ring #(.RST_LIM(ST_RST_LIM)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lim   (reg_wr && reg_sel == SEL_ST_LIM),
    .wr_cons  (reg_wr && reg_sel == SEL_ST_CONS),
    .wdata    (reg_wdata[ST_PW-1:0]),
    .push     (acc_fire),
    .prod_pos (st_prod),
    .empty    (st_empty),
    .full     (st_full_w)
  );

  rxr_router u_route (
    .ctrl      (ctrl_q),
    .halted    (halted_q),
    .frm_valid (frm_valid),
    .frm_len   (frm_len),
    .sm_avail  (ring_avail[0]),
    .lg_avail  (ring_avail[1]),
    .st_full   (st_full_w),
    .accept    (acc_fire),
    .drop      (drop_fire),
    .use_large (use_large)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid   <= 1'b0;
      st_len     <= '0;
      st_ring    <= 1'b0;
      st_bidx    <= '0;
      st_slot    <= '0;
      drop_pulse <= 1'b0;
      drop_cnt   <= '0;
    end else begin
      st_valid   <= acc_fire;
      drop_pulse <= drop_fire;
      if (acc_fire) begin
        st_len  <= frm_len;
        st_ring <= use_large;
        st_bidx <= use_large ? ring_cons[1][FB_IW-1:0] : ring_cons[0][FB_IW-1:0];
        st_slot <= st_prod[ST_IW-1:0];
      end
      if (drop_fire) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  assign lg_cons_pos = ring_cons[1];
  assign wb_pos      = st_prod;
  assign halted      = halted_q;
  assign low_small   = ring_low[0];
  assign low_large   = ring_low[1];
endmodule

// File: rtl/rxring_ptr_mgr_chk.sv
module rxring_ptr_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        frm_valid,
  input logic        acc_fire,
  input logic        drop_fire,
  input logic        use_large,
  input logic        sm_avail,
  input logic        lg_avail,
  input logic        st_full,
  input logic        st_valid,
  input logic        drop_pulse,
  input logic [15:0] drop_cnt,
  input logic [12:0] wb_pos,
  input logic [10:0] lg_cons
);
  p_halt_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && frm_valid) |=> (!st_valid && !drop_pulse));

  p_take_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (use_large ? lg_avail : sm_avail));

  p_drop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |=> (drop_cnt == 16'($past(drop_cnt) + 1)));

  p_wb_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (wb_pos != $past(wb_pos)));

  p_lg_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lg_cons[9:0]) != 10'd0 && lg_cons[9:0] == 10'd0) |-> (lg_cons[10] != $past(lg_cons[10])));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> !acc_fire);
endmodule

bind rxring_ptr_mgr rxring_ptr_mgr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halted     (halted),
  .frm_valid  (frm_valid),
  .acc_fire   (acc_fire),
  .drop_fire  (drop_fire),
  .use_large  (use_large),
  .sm_avail   (ring_avail[0]),
  .lg_avail   (ring_avail[1]),
  .st_full    (st_full_w),
  .st_valid   (st_valid),
  .drop_pulse (drop_pulse),
  .drop_cnt   (drop_cnt),
  .wb_pos     (wb_pos),
  .lg_cons    (lg_cons_pos)
);

// File: tb/rxring_ptr_mgr_tb.sv
module rxring_ptr_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [13:0] reg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic        st_valid, st_ring, st_empty, halted, low_small, low_large, drop_pulse;
  logic [15:0] st_len, drop_cnt;
  logic [9:0]  st_bidx;
  logic [11:0] st_slot;
  logic [12:0] wb_pos;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model state
  int sm_cons = 0, lg_cons = 0, lg_full = 'h400, st_prod = 0, drops = 0;

  // length, accepted, ring, buffer index
  localparam int unsigned TV [0:7][0:3] = '{
    '{64, 1, 0, 0}, '{256, 1, 0, 1}, '{257, 1, 1, 0}, '{1500, 1, 1, 1},
    '{100, 1, 0, 2}, '{200, 1, 0, 3}, '{100, 0, 0, 0}, '{2049, 0, 0, 0}};

  always #2 clk = ~clk;

  rxring_ptr_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frm_valid(frm_valid), .frm_len(frm_len), .st_valid(st_valid), .st_len(st_len),
    .st_ring(st_ring), .st_bidx(st_bidx), .st_slot(st_slot), .wb_pos(wb_pos),
    .st_empty(st_empty), .halted(halted), .low_small(low_small), .low_large(low_large),
    .drop_pulse(drop_pulse), .drop_cnt(drop_cnt));

  function automatic int step(int pos, int iw, int lim);
    int i = pos % (1 << iw);
    int w = (pos >> iw) & 1;
    if (i == lim) begin i = 0; w = 1 - w; end
    else i = i + 1;
    return w * (1 << iw) + i;
  endfunction

  function automatic int navail(int full, int cons, int lim);
    int fi = full % 1024, ci = cons % 1024;
    if (((full >> 10) & 1) != ((cons >> 10) & 1)) return lim + 1 - ci + fi;
    return fi - ci;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 4'(sel); reg_wdata = 14'(data);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic frame(int len);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // check an accepted frame and advance the model
  task automatic expect_acc(string req, int len, int ring, int bidx);
    chk(req, {st_valid, st_ring, st_bidx, st_slot, st_len},
        {1'b1, 1'(ring), 10'(bidx), 12'(st_prod % 4096), 16'(len)});
    st_prod = step(st_prod, 12, 7);
    if (ring == 0) sm_cons = step(sm_cons, 10, 3);
    else lg_cons = step(lg_cons, 10, 1023);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    checks++; fails++;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {halted, st_empty, st_valid, drop_pulse, low_small, low_large}, 6'b110000);
    chk("R1", {wb_pos, drop_cnt}, 29'd0);

    wr(3, 3); wr(4, 1023); wr(7, 7);
    wr(0, 'h2500);
    chk("R2", halted, 0);

    // R4 R5 R7 table walk
    for (int k = 0; k < 8; k++) begin
      frame(int'(TV[k][0]));
      if (TV[k][1] == 1) expect_acc("R4/R5", int'(TV[k][0]), int'(TV[k][2]), int'(TV[k][3]));
      else begin
        chk("R7/R4", {drop_pulse, st_valid}, 2'b10);
        drops++;
      end
    end
    chk("R7", drop_cnt, drops);
    chk("R8", wb_pos, st_prod);
    chk("R9", st_empty, 0);
    wr(8, st_prod);
    chk("R9", st_empty, 1);

    // return the four small buffers: full position after four steps from 0x400 is 0
    wr(1, 0);
    wr(5, 5);
    chk("R10", low_small, 1);
    wr(5, 4);
    chk("R10", low_small, 0);
    frame(100);
    expect_acc("R6", 100, 0, 0);
    chk("R10", low_small, 1);

    // R2 halt value and R3 ignored frame
    wr(0, 'h2001);
    chk("R2", halted, 1);
    frame(100);
    chk("R3", {st_valid, drop_pulse}, 2'b00);
    chk("R3", drop_cnt, drops);
    wr(0, 'h2000);
    chk("R2", halted, 0);
    frame(100);
    expect_acc("R4", 100, 1, 2);
    chk("R8", wb_pos, 'h1000);

    // R9 status ring fills
    wr(8, st_prod);
    for (int k = 0; k < 8; k++) begin
      frame(1500);
      expect_acc("R9", 1500, 1, lg_cons % 1024);
    end
    frame(1500);
    chk("R9", {drop_pulse, st_valid}, 2'b10);
    drops++;
    chk("R9", drop_cnt, drops);

    // R6 long run across the 1024-entry carry
    wr(8, st_prod);
    for (int k = 0; k < 1100; k++) begin
      frame(1500);
      expect_acc("R6", 1500, 1, lg_cons % 1024);
      lg_full = step(lg_full, 10, 1023);
      wr(2, lg_full);
      wr(8, st_prod);
    end
    chk("R8", wb_pos, st_prod);
    chk("R9", st_empty, 1);
    chk("R7", drop_cnt, drops);
    wr(6, navail(lg_full, lg_cons, 1023) + 1);
    chk("R10", low_large, 1);
    wr(6, navail(lg_full, lg_cons, 1023));
    chk("R10", low_large, 0);

    summary();
  end
endmodule